// File: doc/BRIEF.md
# Serial Number Frame Validator

This block checks an eight-byte factory serial number as it arrives one byte at a time from some upstream fetch logic. The first byte must equal the fixed identifier value A0h. The next six bytes form a 48-bit unique number, which the block captures and drives on a parallel output. The last byte must equal an 8-bit CRC that the block computes over the seven bytes before it.

Each byte is presented with a one-cycle valid strobe, and the byte stream may pause between bytes. A start-of-frame pulse begins a new frame and clears all state. If the pulse comes in the same cycle as a valid byte, that byte is taken as byte 0. One cycle after the eighth byte, a done strobe pulses. The identifier and CRC verdicts then stay on their flags until the next start-of-frame.

Top module: `snv_validator`

## Requirements
- R1: After reset, done_o, id_ok_o and crc_ok_o are 0 and uid_o is all zeros.
- R2: A byte is accepted in every cycle where byte_valid_i is 1, up to eight bytes per frame. Idle cycles between bytes do not change the byte position.
- R3: id_ok_o goes to 1 in the cycle after byte 0 is accepted if that byte equals A0h. Otherwise it goes to 0.
- R4: Byte 1 is captured into uid_o[47:40], byte 2 into uid_o[39:32], and so on down to byte 6 in uid_o[7:0]. Each byte is visible in the cycle after it is accepted.
- R5: The CRC uses the polynomial x^8+x^5+x^4+1 in reflected form (feedback constant 8Ch), starts at 00h, and shifts each byte in LSB first over bytes 0 to 6. crc_ok_o goes to 1 in the cycle after byte 7 if byte 7 equals that CRC. For example, bytes 02 1C B8 01 00 00 00 give A2h.
- R6: done_o is 1 for exactly one cycle, the cycle after byte 7 is accepted.
- R7: Bytes that arrive after the eighth byte of a frame are ignored. done_o does not pulse, and uid_o, id_ok_o and crc_ok_o do not change.
- R8: sof_i clears the byte position, the CRC state, uid_o and both flags. A byte that is valid in the same cycle as sof_i is taken as byte 0 of the new frame.
- R9: id_ok_o and crc_ok_o keep their values after done_o until the next sof_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse |
| byte_valid_i | input | 1 | byte_i carries a byte this cycle |
| byte_i | input | 8 | Serial-number byte |
| done_o | output | 1 | One-cycle pulse after the eighth byte |
| id_ok_o | output | 1 | Byte 0 matched the identifier |
| crc_ok_o | output | 1 | Byte 7 matched the computed CRC |
| uid_o | output | 48 | Captured unique number |

## Verification
The hardest case to reach from the ports is a start pulse arriving together with a valid byte, in the middle of an unfinished frame. In that case the clear and the new byte 0 must both take effect in the same cycle. The bench reaches it by abandoning a partial frame and starting the next frame with the start pulse and the identifier byte together. It also ends a frame with the start pulse alone, then sends surplus bytes after a completed frame. Frames are run both back to back and with idle gaps, so the byte position is checked against stalls.

// File: rtl/snv_pkg.sv
// Package: shared constants and the reflected CRC-8 byte step.
// Assumes bytes are shifted in least significant bit first.
package snv_pkg;
    localparam int BYTE_W = 8;

    // One byte through a reflected CRC-8, one bit per loop pass.
    function automatic logic [BYTE_W-1:0] crc_refl_byte(
        input logic [BYTE_W-1:0] crc_in,
        input logic [BYTE_W-1:0] data,
        input logic [BYTE_W-1:0] poly_refl
    );
        logic [BYTE_W-1:0] c;
        logic              fb;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[0] ^ data[i];
            c  = c >> 1;
            if (fb) c = c ^ poly_refl;
        end
        return c;
    endfunction
endpackage

// File: rtl/snv_byte_tracker.sv
// Module: tracks the byte position within a frame.
// Assumes sof_i resets the position and that a byte valid with sof_i is byte 0.
// Outputs the effective slot of the current byte and whether it is accepted.
module snv_byte_tracker #(
    parameter int FRAME_BYTES = 8,
    localparam int IDX_W = $clog2(FRAME_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             valid_i,
    output logic             accept_o,
    output logic [IDX_W-1:0] slot_o
);
    localparam logic [IDX_W-1:0] FULL = IDX_W'(FRAME_BYTES);

    logic [IDX_W-1:0] cnt_q;

    // Effective slot and acceptance, with sof_i overriding the stored count.
    always_comb begin
        slot_o   = sof_i ? '0 : cnt_q;
        accept_o = valid_i && (sof_i || (cnt_q < FULL));
    end

    // Count accepted bytes, restarting on sof_i.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (sof_i)     cnt_q <= valid_i ? IDX_W'(1) : '0;
        else if (accept_o)  cnt_q <= cnt_q + IDX_W'(1);
    end

    // R2: the position never runs past the frame length.
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R7: once the frame is full, bytes without sof_i do not move the count.
    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL && !sof_i) |=> cnt_q == FULL);
endmodule

// File: rtl/snv_crc8.sv
// Module: running reflected CRC-8 over accepted bytes.
// Assumes clear_i restarts at INIT, and an update in the same cycle starts from INIT.
module snv_crc8 #(
    parameter logic [7:0] POLY_REFL = 8'h8C,
    parameter logic [7:0] INIT      = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       update_i,
    input  logic [7:0] data_i,
    output logic [7:0] crc_o
);
    import snv_pkg::*;

    logic [7:0] crc_q;
    logic [7:0] base;

    // Start point for this cycle's byte.
    always_comb base = clear_i ? INIT : crc_q;

    // Hold, clear or advance the CRC state.
    always_ff @(posedge clk) begin
        if (!rst_n)        crc_q <= INIT;
        else if (update_i) crc_q <= crc_refl_byte(base, data_i, POLY_REFL);
        else if (clear_i)  crc_q <= INIT;
    end

    assign crc_o = crc_q;

    // R5: with no byte and no clear, the state does not move.
    a_r5_crc_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_i && !clear_i) |=> $stable(crc_q));

    // R8: a clear without a byte returns the state to INIT.
    a_r8_crc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !update_i) |=> crc_q == INIT);
endmodule

// File: rtl/snv_uid_capture.sv
// Module: captures the middle bytes of the frame into a wide register.
// Assumes slot 1 is the most significant byte and the last middle slot is the least.
module snv_uid_capture #(
    parameter int UID_BYTES = 6,
    parameter int IDX_W     = 4,
    localparam int UID_W    = UID_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             accept_i,
    input  logic [IDX_W-1:0] slot_i,
    input  logic [7:0]       data_i,
    output logic [UID_W-1:0] uid_o
);
    for (genvar k = 0; k < UID_BYTES; k++) begin : g_field
        localparam logic [IDX_W-1:0] MY_SLOT = IDX_W'(k + 1);
        localparam int               LSB     = (UID_BYTES - 1 - k) * 8;
        logic [7:0] field_q;

        // Load this field when its slot arrives, and clear it on start.
        always_ff @(posedge clk) begin
            if (!rst_n)                            field_q <= '0;
            else if (accept_i && slot_i == MY_SLOT) field_q <= data_i;
            else if (clear_i)                      field_q <= '0;
        end

        assign uid_o[LSB +: 8] = field_q;
    end

    // R4: the captured value moves only when a byte is accepted or a clear comes.
    a_r4_uid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_i && !clear_i) |=> $stable(uid_o));
endmodule

// File: rtl/snv_validator.sv
// Module: top of the serial number frame validator.
// Checks the identifier in byte 0, captures bytes 1..6, and compares byte 7
// with the CRC of bytes 0..6. Assumes an upstream source delivers the bytes in order.
module snv_validator #(
    parameter int         FRAME_BYTES = 8,
    parameter logic [7:0] ID_VALUE    = 8'hA0,
    parameter logic [7:0] POLY_REFL   = 8'h8C,
    parameter logic [7:0] CRC_INIT    = 8'h00,
    localparam int        UID_BYTES   = FRAME_BYTES - 2,
    localparam int        UID_W       = UID_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_i,
    output logic             done_o,
    output logic             id_ok_o,
    output logic             crc_ok_o,
    output logic [UID_W-1:0] uid_o
);
    localparam int               IDX_W     = $clog2(FRAME_BYTES + 1);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(FRAME_BYTES - 1);

    logic             accept;
    logic [IDX_W-1:0] slot;
    logic [7:0]       crc_cur;
    logic             crc_upd;
    logic             is_last;
    logic             done_q, id_ok_q, crc_ok_q;

    snv_byte_tracker #(.FRAME_BYTES(FRAME_BYTES)) u_track (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .valid_i(byte_valid_i),
        .accept_o(accept), .slot_o(slot)
    );

    // Bytes before the last one feed the CRC.
    always_comb begin
        is_last = accept && (slot == LAST_SLOT);
        crc_upd = accept && (slot < LAST_SLOT);
    end

    snv_crc8 #(.POLY_REFL(POLY_REFL), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear_i(sof_i), .update_i(crc_upd),
        .data_i(byte_i), .crc_o(crc_cur)
    );

    snv_uid_capture #(.UID_BYTES(UID_BYTES), .IDX_W(IDX_W)) u_uid (
        .clk(clk), .rst_n(rst_n), .clear_i(sof_i), .accept_i(accept),
        .slot_i(slot), .data_i(byte_i), .uid_o(uid_o)
    );

    // Identifier verdict, set on byte 0 and cleared on start.
    always_ff @(posedge clk) begin
        if (!rst_n)                     id_ok_q <= 1'b0;
        else if (accept && slot == '0)  id_ok_q <= (byte_i == ID_VALUE);
        else if (sof_i)                 id_ok_q <= 1'b0;
    end

    // CRC verdict, set on the last byte and cleared on start.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_ok_q <= 1'b0;
        else if (sof_i)   crc_ok_q <= 1'b0;
        else if (is_last) crc_ok_q <= (crc_cur == byte_i);
    end

    // Completion pulse for the cycle after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= is_last;
    end

    assign done_o   = done_q;
    assign id_ok_o  = id_ok_q;
    assign crc_ok_o = crc_ok_q;

    // R6: the completion pulse lasts a single cycle.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: the CRC verdict can only rise together with completion.
    a_r5_crc_rise_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_ok_o) |-> done_o);

    // R8: a start with no byte clears both flags and the captured value.
    a_r8_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && !byte_valid_i) |=> (!id_ok_o && !crc_ok_o && uid_o == '0));

    // R9: without a start or a byte, the flags hold.
    a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_i && !byte_valid_i) |=> ($stable(id_ok_o) && $stable(crc_ok_o)));
endmodule

// File: tb/snv_validator_test.sv
module snv_validator_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        done_o, id_ok_o, crc_ok_o;
    logic [47:0] uid_o;

    int tests = 0;
    int failed = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snv_validator uut (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .done_o(done_o), .id_ok_o(id_ok_o),
        .crc_ok_o(crc_ok_o), .uid_o(uid_o)
    );

    // Vector: {uid[47:0], bad_id, bad_crc, gaps}
    localparam logic [50:0] VEC [0:4] = '{
        {48'h0123456789AB, 1'b0, 1'b0, 1'b0},
        {48'hFFFFFFFFFFFF, 1'b0, 1'b0, 1'b1},
        {48'h000000000000, 1'b1, 1'b0, 1'b0},
        {48'hDEADBEEF5A5A, 1'b0, 1'b1, 1'b1},
        {48'h13579BDF2468, 1'b1, 1'b1, 1'b0}
    };

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int b = 0; b < 8; b++) begin
            if ((r[0] ^ d[b]) == 1'b1) r = (r >> 1) ^ 8'h8C;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic s);
        @(negedge clk);
        byte_valid_i = 1'b1; byte_i = b; sof_i = s;
        @(negedge clk);
        byte_valid_i = 1'b0; sof_i = 1'b0;
    endtask

    task automatic pulse_sof();
        @(negedge clk); sof_i = 1'b1;
        @(negedge clk); sof_i = 1'b0;
    endtask

    // Send a full frame; the last sample point is the cycle done should be high.
    task automatic frame(input logic [7:0] f [0:7], input logic gaps);
        for (int k = 0; k < 8; k++) begin
            send(f[k], k == 0);
            if (k < 7) chk("R6 no early done", done_o, 0);
            if (gaps) @(negedge clk);
        end
    endtask

    task automatic build(input logic [47:0] uid, input logic bad_id, input logic bad_crc,
                         output logic [7:0] f [0:7]);
        logic [7:0] c = 8'h00;
        f[0] = bad_id ? 8'hA1 : 8'hA0;
        for (int k = 1; k <= 6; k++) f[k] = uid[(6-k)*8 +: 8];
        for (int k = 0; k < 7; k++) c = ref_crc(c, f[k]);
        f[7] = c ^ (bad_crc ? 8'h01 : 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; failed++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        logic [7:0] f [0:7];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", done_o, 0);
        chk("R1 id_ok", id_ok_o, 0);
        chk("R1 crc_ok", crc_ok_o, 0);
        chk("R1 uid", uid_o, 0);

        // Table walk (R2, R3, R4, R5, R6, R9)
        for (int v = 0; v < 5; v++) begin
            build(VEC[v][50:3], VEC[v][2], VEC[v][1], f);
            frame(f, VEC[v][0]);
            chk("R6 done pulse", done_o, (!VEC[v][0]) ? 1 : 0);
            if (VEC[v][0]) begin
                // With gaps, the pulse already passed during the trailing idle cycle.
                chk("R9 id_ok held", id_ok_o, !VEC[v][2]);
            end
            chk("R3 id_ok", id_ok_o, !VEC[v][2]);
            chk("R5 crc_ok", crc_ok_o, !VEC[v][1]);
            chk("R4 uid", uid_o, VEC[v][50:3]);
            @(negedge clk);
            chk("R6 done one cycle", done_o, 0);
            chk("R9 crc_ok held", crc_ok_o, !VEC[v][1]);
        end

        // R5 known reference vector, with a non-matching identifier
        f = '{8'h02, 8'h1C, 8'hB8, 8'h01, 8'h00, 8'h00, 8'h00, 8'hA2};
        frame(f, 1'b0);
        chk("R6 known done", done_o, 1);
        chk("R5 known crc_ok", crc_ok_o, 1);
        chk("R3 known id_ok", id_ok_o, 0);
        chk("R4 known uid", uid_o, 48'h1CB801000000);

        // R7 surplus bytes after a completed frame
        for (int k = 0; k < 3; k++) begin
            send(8'h55, 1'b0);
            chk("R7 no done", done_o, 0);
        end
        chk("R7 uid unchanged", uid_o, 48'h1CB801000000);
        chk("R7 crc_ok unchanged", crc_ok_o, 1);
        chk("R7 id_ok unchanged", id_ok_o, 0);

        // R3 and R4 partial visibility, then R8 sof alone mid-frame
        send(8'hA0, 1'b1);
        chk("R3 id_ok after byte0", id_ok_o, 1);
        chk("R8 sof cleared crc_ok", crc_ok_o, 0);
        send(8'h9C, 1'b0);
        chk("R4 byte1 position", uid_o, 48'h9C0000000000);
        send(8'h33, 1'b0);
        pulse_sof();
        chk("R8 sof clears uid", uid_o, 0);
        chk("R8 sof clears id_ok", id_ok_o, 0);

        // R8 sof with byte mid-frame: abandon a partial frame, then restart with byte 0
        send(8'hA0, 1'b1);
        send(8'h11, 1'b0);
        build(48'hA1B2C3D4E5F6, 1'b0, 1'b0, f);
        frame(f, 1'b0);
        chk("R8 restart done", done_o, 1);
        chk("R8 restart crc_ok", crc_ok_o, 1);
        chk("R8 restart uid", uid_o, 48'hA1B2C3D4E5F6);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule